// File: doc/BRIEF.md
# Status Register and Ready Pin Controller

This block holds the status byte that a flash-style write automation engine exposes to the host. It also drives the open-drain ready/status pin. It watches the engine's level signals and its event strobes. The level signals are busy, erase-suspended and program-suspended. The event strobes are erase done, program done and four error kinds. From these it keeps sticky error flags and live state flags in the status byte.

The pin has two kinds of behaviour:

- **Level mode**, the default: the pin acts as a ready/busy line.
- **Pulse modes**, selected by a configuration write: the pin stays released and pulls low for a fixed number of clocks when an erase, a program, or either one completes.

A host clear strobe wipes the error flags. A power-down request returns everything to its reset state. If power-down cuts off an operation that is running, the pin stays low for a fixed internal reset interval.

The pin is open-drain. The port `rdy_pull_low` is the pull-down enable, and an external pull-up supplies the released (high) level.

Top module: `stsreg_ready_ctrl`

## Requirements
- R1: After `rst`, `status` reads 8'h80, `rdy_pull_low` is 0 and the signalling mode is level mode.
- R2: In level mode, `rdy_pull_low` equals, one clock later, `eng_busy` AND NOT `eng_prg_susp`. The pin is therefore released when the engine is idle, when an erase is suspended and no program runs, and when a program is suspended.
- R3: Status bit 7 (ready) is NOT `eng_busy`, bit 6 is `eng_ers_susp` and bit 2 is `eng_prg_susp`, each sampled one clock earlier.
- R4: Error flags live in status bit 5 (erase error), bit 4 (program error) and bit 3 (voltage error). A lock error sets bits 5 and 4 together. Each flag is sticky until `clr_sts` or power-down. An error event in the same clock as `clr_sts` leaves its flag set.
- R5: Status bits 1 and 0 always read 0.
- R6: A `cfg_wr` takes the code on `cfg_code` as follows: 8'h00 selects level mode, 8'h01 pulse on erase completion, 8'h02 pulse on program completion, 8'h03 pulse on both. Any other code leaves the mode unchanged.
- R7: In erase-pulse mode, `eng_done_ers` makes `rdy_pull_low` 1 for exactly PULSE_CYC clocks, starting the next clock. `eng_done_prg` and `eng_busy` do not move the pin in this mode.
- R8: In program-pulse mode, `eng_done_prg` makes a PULSE_CYC-clock low pulse, and `eng_done_ers` has no effect on the pin.
- R9: In the both-pulse mode, either completion strobe starts the pulse.
- R10: A completion strobe that arrives during a pulse restarts the pulse at its full PULSE_CYC length.
- R11: While `pwrdn` is 1, `status` reads 8'h80, the mode returns to level, any pulse is cancelled and the error flags are cleared. The pin is released unless R12 applies.
- R12: If `pwrdn` rises while `eng_busy` is 1 and `eng_prg_susp` is 0, `rdy_pull_low` stays 1 for ABORT_CYC clocks from that edge, then releases.
- R13: An accepted configuration write cancels any pulse in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrdn | input | 1 | Reset/power-down request from the device pin |
| eng_busy | input | 1 | Engine is executing an algorithm |
| eng_ers_susp | input | 1 | Erase is suspended |
| eng_prg_susp | input | 1 | Program is suspended |
| eng_done_ers | input | 1 | One-clock strobe: erase finished |
| eng_done_prg | input | 1 | One-clock strobe: program finished |
| eng_err_ers | input | 1 | One-clock strobe: erase failure |
| eng_err_prg | input | 1 | One-clock strobe: program failure |
| eng_err_vpp | input | 1 | One-clock strobe: programming voltage too low |
| eng_err_lock | input | 1 | One-clock strobe: lock-bit operation failure |
| clr_sts | input | 1 | Clear the sticky error flags |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_code | input | 8 | Configuration code |
| status | output | 8 | Status byte |
| rdy_pull_low | output | 1 | 1 = pull the open-drain pin low |

## Verification
A wrong mode register shows up at the pin at the next busy or completion event. A stray pulse or a missing pulse then appears within one clock, so the bench mixes busy activity and completion strobes in every mode. A pulse counter that loads or counts wrongly shows up as a low window that is too long or too short, seen at the clock where the release is due. Flag errors show up in the status byte one clock after the event that sets or clears them. The bench compares the byte and the pin against a behavioural model on every clock.

// File: rtl/stsrdy_pkg.sv
package stsrdy_pkg;

    typedef enum logic [1:0] {
        SIG_LEVEL = 2'b00,
        SIG_ERS   = 2'b01,
        SIG_PRG   = 2'b10,
        SIG_BOTH  = 2'b11
    } sig_mode_e;

    typedef struct packed {
        logic       ready;
        logic       ers_susp;
        logic       ers_err;
        logic       prg_err;
        logic       vpp_err;
        logic       prg_susp;
        logic [1:0] rsvd;
    } sts_byte_t;

    localparam sts_byte_t STS_IDLE = sts_byte_t'(8'h80);

    function automatic logic code_ok(input logic [7:0] c);
        return (c[7:2] == 6'd0);
    endfunction

    function automatic logic pulse_hit(input sig_mode_e m, input logic de, input logic dp);
        logic [1:0] mb;
        mb = m;
        return (mb[0] & de) | (mb[1] & dp);
    endfunction

endpackage

// File: rtl/stsrdy_lowtimer.sv
module stsrdy_lowtimer #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic start,
    output logic active
);
    localparam int W = $clog2(LEN + 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (start)
            cnt_q <= W'(LEN);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);

    // R7 / R10: a window never ends before its count is spent
    p_no_early_end_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> ($past(cnt_q) == W'(1) || $past(clear)));

endmodule

// File: rtl/stsrdy_mode_reg.sv
module stsrdy_mode_reg
    import stsrdy_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pwrdn,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_code,
    output sig_mode_e  mode,
    output logic       cfg_take
);
    sig_mode_e mode_q;

    assign cfg_take = cfg_wr && code_ok(cfg_code) && !pwrdn;

    always_ff @(posedge clk) begin
        if (rst || pwrdn)
            mode_q <= SIG_LEVEL;
        else if (cfg_take)
            mode_q <= sig_mode_e'(cfg_code[1:0]);
    end

    assign mode = mode_q;

    // R6: unknown codes leave the mode untouched
    p_bad_code_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !code_ok(cfg_code) && !pwrdn) |=> $stable(mode_q));

endmodule

// File: rtl/stsrdy_status.sv
module stsrdy_status
    import stsrdy_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pwrdn,
    input  logic      clr,
    input  logic      busy,
    input  logic      ers_susp,
    input  logic      prg_susp,
    input  logic      err_ers,
    input  logic      err_prg,
    input  logic      err_vpp,
    input  logic      err_lock,
    output sts_byte_t sts
);
    sts_byte_t sts_q;

    always_ff @(posedge clk) begin
        if (rst || pwrdn) begin
            sts_q <= STS_IDLE;
        end else begin
            sts_q.ready    <= ~busy;
            sts_q.ers_susp <= ers_susp;
            sts_q.prg_susp <= prg_susp;
            sts_q.ers_err  <= (sts_q.ers_err & ~clr) | err_ers | err_lock;
            sts_q.prg_err  <= (sts_q.prg_err & ~clr) | err_prg | err_lock;
            sts_q.vpp_err  <= (sts_q.vpp_err & ~clr) | err_vpp;
            sts_q.rsvd     <= 2'b00;
        end
    end

    assign sts = sts_q;

    // R3: ready bit follows the engine one clock later
    p_ready_follow_r3: assert property (@(posedge clk) disable iff (rst)
        !pwrdn |=> (sts_q.ready == !$past(busy)));

    // R4: flags survive until a clear or power-down
    p_sticky_ers_r4: assert property (@(posedge clk) disable iff (rst)
        (sts_q.ers_err && !clr && !pwrdn) |=> sts_q.ers_err);

    p_sticky_vpp_r4: assert property (@(posedge clk) disable iff (rst)
        (sts_q.vpp_err && !clr && !pwrdn) |=> sts_q.vpp_err);

    // R4: lock failure reports on both error bits
    p_lock_pair_r4: assert property (@(posedge clk) disable iff (rst)
        (err_lock && !pwrdn) |=> (sts_q.ers_err && sts_q.prg_err));

endmodule

// File: rtl/stsreg_ready_ctrl.sv
module stsreg_ready_ctrl
    import stsrdy_pkg::*;
#(
    parameter int PULSE_CYC = 4,
    parameter int ABORT_CYC = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwrdn,
    input  logic       eng_busy,
    input  logic       eng_ers_susp,
    input  logic       eng_prg_susp,
    input  logic       eng_done_ers,
    input  logic       eng_done_prg,
    input  logic       eng_err_ers,
    input  logic       eng_err_prg,
    input  logic       eng_err_vpp,
    input  logic       eng_err_lock,
    input  logic       clr_sts,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_code,
    output logic [7:0] status,
    output logic       rdy_pull_low
);
    sig_mode_e mode;
    sts_byte_t sts;
    logic      cfg_take;
    logic      running;
    logic      lvl_q;
    logic      pdn_q;
    logic      pulse_go;
    logic      pulse_clr;
    logic      abort_go;
    logic      pulse_act;
    logic      abort_act;

    assign running   = eng_busy & ~eng_prg_susp;
    assign pulse_go  = pulse_hit(mode, eng_done_ers, eng_done_prg);
    assign pulse_clr = pwrdn | cfg_take;
    assign abort_go  = pwrdn & ~pdn_q & running;

    stsrdy_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .pwrdn    (pwrdn),
        .cfg_wr   (cfg_wr),
        .cfg_code (cfg_code),
        .mode     (mode),
        .cfg_take (cfg_take)
    );

    stsrdy_status u_sts (
        .clk      (clk),
        .rst      (rst),
        .pwrdn    (pwrdn),
        .clr      (clr_sts),
        .busy     (eng_busy),
        .ers_susp (eng_ers_susp),
        .prg_susp (eng_prg_susp),
        .err_ers  (eng_err_ers),
        .err_prg  (eng_err_prg),
        .err_vpp  (eng_err_vpp),
        .err_lock (eng_err_lock),
        .sts      (sts)
    );

    stsrdy_lowtimer #(.LEN(PULSE_CYC)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .clear  (pulse_clr),
        .start  (pulse_go),
        .active (pulse_act)
    );

    stsrdy_lowtimer #(.LEN(ABORT_CYC)) u_abort (
        .clk    (clk),
        .rst    (rst),
        .clear  (1'b0),
        .start  (abort_go),
        .active (abort_act)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            pdn_q <= 1'b0;
        end else begin
            lvl_q <= running & ~pwrdn;
            pdn_q <= pwrdn;
        end
    end

    assign status       = sts;
    assign rdy_pull_low = ((mode == SIG_LEVEL) ? lvl_q : pulse_act) | abort_act;

    // R2: level mode tracks the running state
    p_level_track_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == SIG_LEVEL && !pwrdn && !cfg_take && !abort_act)
        |=> (rdy_pull_low == $past(eng_busy && !eng_prg_susp)));

    // R11: power-down restores the idle byte and level mode
    p_pdn_idle_r11: assert property (@(posedge clk) disable iff (rst)
        pwrdn |=> (status == 8'h80 && mode == SIG_LEVEL));

    // R12: an aborted operation keeps the pin low
    p_abort_low_r12: assert property (@(posedge clk) disable iff (rst)
        (pwrdn && !pdn_q && eng_busy && !eng_prg_susp) |=> rdy_pull_low);

    // R7: a completion in a matching pulse mode pulls the pin low
    p_pulse_start_r7: assert property (@(posedge clk) disable iff (rst)
        (mode != SIG_LEVEL && !pulse_clr && pulse_go) |=> rdy_pull_low);

endmodule

// File: tb/sim_stsreg_ready_ctrl.sv
module sim_stsreg_ready_ctrl;
    localparam int P = 4;
    localparam int A = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst, pwrdn, busy, esusp, psusp, d_ers, d_prg;
    logic       e_ers, e_prg, e_vpp, e_lock, clr, cfg_wr;
    logic [7:0] cfg_code;
    logic [7:0] status;
    logic       pin;

    int    tests = 0;
    int    fails = 0;
    string cur_req = "R1";

    stsreg_ready_ctrl #(.PULSE_CYC(P), .ABORT_CYC(A)) u0 (
        .clk(clk), .rst(rst), .pwrdn(pwrdn), .eng_busy(busy),
        .eng_ers_susp(esusp), .eng_prg_susp(psusp),
        .eng_done_ers(d_ers), .eng_done_prg(d_prg),
        .eng_err_ers(e_ers), .eng_err_prg(e_prg), .eng_err_vpp(e_vpp),
        .eng_err_lock(e_lock), .clr_sts(clr), .cfg_wr(cfg_wr),
        .cfg_code(cfg_code), .status(status), .rdy_pull_low(pin)
    );

    // behavioural reference
    int         m_mode, m_pcnt, m_acnt;
    logic       m_lvl, m_pdq, m_e5, m_e4, m_e3;
    logic [7:0] m_sts;

    task automatic model_update();
        if (rst) begin
            m_mode = 0; m_pcnt = 0; m_acnt = 0; m_lvl = 0; m_pdq = 0;
            m_e5 = 0; m_e4 = 0; m_e3 = 0; m_sts = 8'h80;
        end else begin
            if (pwrdn && !m_pdq && busy && !psusp) m_acnt = A;
            else if (m_acnt > 0) m_acnt = m_acnt - 1;
            if (pwrdn) begin
                m_mode = 0; m_pcnt = 0; m_lvl = 0;
                m_e5 = 0; m_e4 = 0; m_e3 = 0; m_sts = 8'h80;
            end else begin
                m_lvl = busy && !psusp;
                if (clr) begin m_e5 = 0; m_e4 = 0; m_e3 = 0; end
                if (e_ers || e_lock) m_e5 = 1;
                if (e_prg || e_lock) m_e4 = 1;
                if (e_vpp) m_e3 = 1;
                m_sts = {~busy, esusp, m_e5, m_e4, m_e3, psusp, 2'b00};
                if (cfg_wr && cfg_code < 8'd4) begin
                    m_mode = int'(cfg_code); m_pcnt = 0;
                end else if (((m_mode & 1) != 0 && d_ers) || ((m_mode & 2) != 0 && d_prg))
                    m_pcnt = P;
                else if (m_pcnt > 0)
                    m_pcnt = m_pcnt - 1;
            end
            m_pdq = pwrdn;
        end
    endtask

    function automatic logic m_pin();
        return ((m_mode == 0) ? m_lvl : (m_pcnt > 0)) || (m_acnt > 0);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        chk({cur_req, " status vs model"}, status, m_sts);
        chk({cur_req, " pin vs model"}, {7'd0, pin}, {7'd0, m_pin()});
        d_ers = 0; d_prg = 0; e_ers = 0; e_prg = 0; e_vpp = 0; e_lock = 0;
        clr = 0; cfg_wr = 0;
    endtask

    task automatic cfg(input logic [7:0] c);
        cfg_wr = 1; cfg_code = c; step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1; pwrdn = 0; busy = 0; esusp = 0; psusp = 0; d_ers = 0; d_prg = 0;
        e_ers = 0; e_prg = 0; e_vpp = 0; e_lock = 0; clr = 0; cfg_wr = 0; cfg_code = 0;
        @(negedge clk);
        step(); step();
        rst = 0; step();
        chk("R1 reset status", status, 8'h80);
        chk("R1 reset pin", {7'd0, pin}, 8'h00);

        cur_req = "R2";
        busy = 1; step();
        chk("R2 busy pulls low", {7'd0, pin}, 8'h01);
        chk("R3 ready clear when busy", {7'd0, status[7]}, 8'h00);
        psusp = 1; step();
        chk("R2 program suspend releases", {7'd0, pin}, 8'h00);
        chk("R3 program suspend bit", status, 8'h04);
        busy = 0; psusp = 0; esusp = 1; step();
        chk("R2 erase suspend releases", {7'd0, pin}, 8'h00);
        chk("R3 erase suspend bits", status, 8'hC0);
        busy = 1; step();
        chk("R2 program during erase suspend", {7'd0, pin}, 8'h01);
        busy = 0; esusp = 0; step();

        cur_req = "R4";
        e_ers = 1; step(); step(); step();
        chk("R4 erase error sticky", status, 8'hA0);
        clr = 1; step();
        chk("R4 clear", status, 8'h80);
        e_lock = 1; step();
        chk("R4 lock error both bits", status, 8'hB0);
        clr = 1; e_vpp = 1; step();
        chk("R4 set wins over clear", status, 8'h88);
        chk("R5 reserved bits zero", {6'd0, status[1:0]}, 8'h00);
        e_prg = 1; step();
        chk("R4 program error", status, 8'h98);
        clr = 1; step();

        cur_req = "R6";
        cfg(8'h05); cfg(8'h80);
        busy = 1; step();
        chk("R6 bad codes keep level mode", {7'd0, pin}, 8'h01);
        busy = 0; step();

        cur_req = "R7";
        cfg(8'h01);
        d_prg = 1; step();
        chk("R7 program done ignored", {7'd0, pin}, 8'h00);
        busy = 1; step();
        chk("R7 busy ignored in pulse mode", {7'd0, pin}, 8'h00);
        busy = 0; d_ers = 1; step();
        chk("R7 pulse starts", {7'd0, pin}, 8'h01);
        step(); step(); step();
        chk("R7 pulse last cycle", {7'd0, pin}, 8'h01);
        step();
        chk("R7 pulse ends", {7'd0, pin}, 8'h00);

        cur_req = "R8";
        cfg(8'h02);
        d_ers = 1; step();
        chk("R8 erase done ignored", {7'd0, pin}, 8'h00);
        d_prg = 1; step();
        chk("R8 program pulse", {7'd0, pin}, 8'h01);
        repeat (P) step();

        cur_req = "R9";
        cfg(8'h03);
        d_ers = 1; step();
        chk("R9 erase pulse", {7'd0, pin}, 8'h01);
        repeat (P) step();
        d_prg = 1; step();
        chk("R9 program pulse", {7'd0, pin}, 8'h01);
        repeat (P) step();

        cur_req = "R10";
        d_ers = 1; step(); step();
        d_prg = 1; step();
        step(); step(); step();
        chk("R10 restarted pulse still low", {7'd0, pin}, 8'h01);
        step();
        chk("R10 restarted pulse ends", {7'd0, pin}, 8'h00);

        cur_req = "R13";
        d_ers = 1; step();
        cfg(8'h03);
        chk("R13 config cancels pulse", {7'd0, pin}, 8'h00);

        cur_req = "R11";
        cfg(8'h01);
        e_vpp = 1; step();
        pwrdn = 1; step();
        chk("R11 power-down status", status, 8'h80);
        chk("R11 power-down pin", {7'd0, pin}, 8'h00);
        pwrdn = 0; busy = 1; step();
        chk("R11 level mode restored", {7'd0, pin}, 8'h01);

        cur_req = "R12";
        pwrdn = 1; step();
        chk("R12 abort holds low", {7'd0, pin}, 8'h01);
        busy = 0;
        repeat (A - 1) step();
        chk("R12 abort last cycle", {7'd0, pin}, 8'h01);
        step();
        chk("R12 abort released", {7'd0, pin}, 8'h00);
        chk("R12 status idle", status, 8'h80);
        pwrdn = 0; step(); step();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule